// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous on-chip requester and an external asynchronous 16-bit static RAM. The RAM has one active-low and one active-high chip enable, an active-low write enable, an active-low output enable and two active-low byte strobes. The requester presents one command at a time on a valid/ready handshake. A command carries a read/write flag, a word address, write data and a byte mask. The controller turns each command into a strobe sequence on the RAM pins. Every phase of that sequence lasts a whole number of clock cycles, and each of those numbers is a parameter with a minimum of 1. A read returns its data with a one-cycle completion pulse. A write also ends with the same pulse.

Between accesses the RAM sits in standby with its output driver off. The controller drives the data bus only while a write is in progress. After a read it waits out a turnaround gap before it drives the bus again. It moves the address only while the write enable and the active-low enable are both released. Pad-level tristating happens outside the block: the controller gives the outgoing data together with a drive-enable, and it takes the incoming bus value on a separate port.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, the RAM pins are in standby: `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, both byte strobes 1, and `mem_dq_drive`=0.
- R2: A read holds `mem_ce_n`=0, `mem_ce`=1, `mem_oe_n`=0 and `mem_we_n`=1 for exactly T_ACC consecutive cycles.
- R3: A write holds `mem_ce_n`=0, `mem_ce`=1 and `mem_we_n`=0 for exactly max(T_WP, T_SETUP) consecutive cycles. `mem_oe_n` stays 1 throughout.
- R4: Byte mask bit 0 asserts strobe bit 0, which covers data bits 7:0. Mask bit 1 asserts strobe bit 1, which covers bits 15:8. Strobes are active only while the RAM is enabled. A write with mask 00 changes no RAM content.
- R5: Read data is taken from the bus in the last access cycle. Lanes not selected by the mask return 0. `rsp_done` rises 2+T_ACC cycles after the accepting clock edge.
- R6: Write data is driven through the whole write-enable-low interval. All strobes and enables rise on the same edge, and the data stays driven with the same value for exactly T_HOLD cycles after that edge.
- R7: `mem_addr` changes only between two cycles in which both `mem_we_n` and `mem_ce_n` are 1. The address of the accepted command is held on `mem_addr` for the whole access.
- R8: The data bus is never driven while `mem_oe_n` is 0, nor in the cycle after. After a read, at least T_TURN cycles with `mem_oe_n`=1 pass before the bus is driven.
- R9: A write that follows a read directly completes in 2+max(T_WP,T_SETUP)+T_HOLD+max(0,T_TURN-2) cycles. Any other write completes in 2+max(T_WP,T_SETUP)+T_HOLD cycles.
- R10: `req_ready` is 0 from the accepting edge until completion. Each accepted command gives exactly one single-cycle `rsp_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Controller idle, command accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Word address |
| req_wdata | input | LANES*LANE_W (16) | Write data |
| req_mask | input | LANES (2) | Byte lane enables, bit 0 = bits 7:0 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | LANES*LANE_W (16) | Read data, valid with rsp_done after a read |
| mem_addr | output | ADDR_W (19) | RAM address |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_byte_n | output | LANES (2) | Active-low byte strobes, bit 0 = lower byte |
| mem_dq_out | output | LANES*LANE_W (16) | Data toward the RAM |
| mem_dq_drive | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | LANES*LANE_W (16) | Data from the RAM pads |

## Verification
The embedded properties check on every cycle that output enable and write enable are never low together, that the pins are in standby whenever the controller is ready, that the address moves only with both write enable and the active-low enable released, that the bus is never driven next to a low output enable, and that the completion pulse lasts a single cycle. The bench's byte-accurate memory model is the only way to show several other behaviours: that data really lands in the selected lanes, that a zero mask writes nothing, that unselected read lanes come back as zero, and that the pulse, hold, access and turnaround lengths and the end-to-end latencies match the configured cycle counts. Those scenarios sweep every mask value across sixteen addresses, with writes placed both directly after reads and directly after writes.

// File: rtl/sram_ctrl_pkg.sv
// Package sram_ctrl_pkg
// Shared sequencer state encoding and small compile-time helpers for the
// asynchronous SRAM controller. Assumes no particular tool or target.
package sram_ctrl_pkg;

    // Phases of one RAM access; IDLE is the only state that accepts a command.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_TURN   = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WHOLD  = 3'd4,
        ST_RACC   = 3'd5
    } seq_state_t;

    // Larger of two cycle counts, used to size the write pulse.
    function automatic int unsigned max_cycles(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Module sram_phase_timer
// Down-counter that measures the length of one access phase. The sequencer
// loads (length-1) on the edge that enters a phase; the phase ends on the
// edge where expired is high. Assumes every phase length is at least 1.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R2/R3/R6: once a phase has run out it stays run out until reloaded.
    p_timer_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sram_gap_tracker.sv
// Module sram_gap_tracker
// Counts the cycles that pass after a read releases output enable, so the
// sequencer knows when it may turn the data bus around and drive it.
// Assumes TURN_CYC >= 1. clear is high once the next edge may start driving.
module sram_gap_tracker #(
    parameter int unsigned TURN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic read_end,
    output logic clear
);

    localparam int unsigned GW = $clog2(TURN_CYC + 1) + 1;

    logic [GW-1:0] gap_q;

    // Restart the turnaround window at the end of each read, then run down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (read_end) begin
            gap_q <= GW'(TURN_CYC);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign clear = (gap_q <= GW'(1));

    // R8: the window never runs past its configured length.
    p_gap_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GW'(TURN_CYC));

endmodule

// File: rtl/sram_lane_decode.sv
// Module sram_lane_decode
// Per-byte-lane logic: turns the byte mask into active-low strobes while a
// strobe phase is active, and zeroes unselected lanes of incoming read data.
// Lane i covers data bits i*LANE_W+LANE_W-1 : i*LANE_W.
module sram_lane_decode #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             strobe_en,
    input  logic [LANES-1:0] mask,
    input  logic [DW-1:0]    dq_in,
    output logic [LANES-1:0] byte_n,
    output logic [DW-1:0]    rdata_masked
);

    // One strobe and one read-data lane per byte lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign byte_n[i] = !(strobe_en && mask[i]);
        assign rdata_masked[i*LANE_W +: LANE_W] =
            mask[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
    end

    // R4: no strobe ever fires outside a strobe phase.
    always_comb begin
        if (!strobe_en) begin
            a_lane_idle_r4: assert (&byte_n);
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Module sram_async_ctrl
// Host-side controller for an asynchronous 16-bit SRAM with dual-polarity
// chip enables, write enable, output enable and per-byte strobes. Accepts one
// command at a time on valid/ready, sequences the pins with programmable
// cycle counts, and returns read data with a one-cycle done pulse.
// Assumes all timing parameters are >= 1 and that pad tristating is done
// outside using mem_dq_drive. RAM pins are decoded from registered state.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 19,
    parameter int unsigned LANES   = 2,
    parameter int unsigned LANE_W  = 8,
    parameter int unsigned T_ACC   = 3,
    parameter int unsigned T_WP    = 2,
    parameter int unsigned T_SETUP = 3,
    parameter int unsigned T_HOLD  = 2,
    parameter int unsigned T_TURN  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [LANES*LANE_W-1:0]   req_wdata,
    input  logic [LANES-1:0]          req_mask,
    output logic                      rsp_done,
    output logic [LANES*LANE_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic                      mem_ce_n,
    output logic                      mem_ce,
    output logic                      mem_we_n,
    output logic                      mem_oe_n,
    output logic [LANES-1:0]          mem_byte_n,
    output logic [LANES*LANE_W-1:0]   mem_dq_out,
    output logic                      mem_dq_drive,
    input  logic [LANES*LANE_W-1:0]   mem_dq_in
);

    localparam int unsigned DW      = LANES * LANE_W;
    localparam int unsigned PULSE   = max_cycles(T_WP, T_SETUP);
    localparam int unsigned LONGEST = max_cycles(max_cycles(T_ACC, PULSE), T_HOLD);
    localparam int unsigned TW      = $clog2(LONGEST + 1) + 1;

    seq_state_t         state_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DW-1:0]      wdata_q;
    logic [LANES-1:0]   mask_q;
    logic               wr_q;
    logic               done_q;
    logic [DW-1:0]      rdata_q;

    logic               tmr_load;
    logic [TW-1:0]      tmr_val;
    logic               tmr_expired;
    logic               gap_clear;
    logic               read_end;
    logic               strobe_en;
    logic [DW-1:0]      lane_rdata;

    // Phase length counter shared by access, pulse and hold phases.
    sram_phase_timer #(.CNT_W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Turnaround window after each read.
    sram_gap_tracker #(.TURN_CYC(T_TURN)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .read_end (read_end),
        .clear    (gap_clear)
    );

    // Byte strobes and read-lane masking.
    sram_lane_decode #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .strobe_en    (strobe_en),
        .mask         (mask_q),
        .dq_in        (mem_dq_in),
        .byte_n       (mem_byte_n),
        .rdata_masked (lane_rdata)
    );

    assign read_end = (state_q == ST_RACC) && tmr_expired;

    // Pick the phase timer reload for the edge that enters a timed phase.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_SETUP: begin
                if (!wr_q) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_ACC - 1);
                end else if (gap_clear) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PULSE - 1);
                end
            end
            ST_TURN: begin
                if (gap_clear) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PULSE - 1);
                end
            end
            ST_WPULSE: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_HOLD - 1);
                end
            end
            default: ;
        endcase
    end

    // Access sequencer: capture the command, step through phases, signal completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        mask_q  <= req_mask;
                        wr_q    <= req_write;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (!wr_q) begin
                        state_q <= ST_RACC;
                    end else if (gap_clear) begin
                        state_q <= ST_WPULSE;
                    end else begin
                        state_q <= ST_TURN;
                    end
                end
                ST_TURN: begin
                    if (gap_clear) begin
                        state_q <= ST_WPULSE;
                    end
                end
                ST_WPULSE: begin
                    if (tmr_expired) begin
                        state_q <= ST_WHOLD;
                    end
                end
                ST_WHOLD: begin
                    if (tmr_expired) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                ST_RACC: begin
                    if (tmr_expired) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        rdata_q <= lane_rdata;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode RAM control pin levels from the current phase.
    always_comb begin
        mem_ce_n     = 1'b1;
        mem_ce       = 1'b0;
        mem_we_n     = 1'b1;
        mem_oe_n     = 1'b1;
        mem_dq_drive = 1'b0;
        strobe_en    = 1'b0;
        unique case (state_q)
            ST_RACC: begin
                mem_ce_n  = 1'b0;
                mem_ce    = 1'b1;
                mem_oe_n  = 1'b0;
                strobe_en = 1'b1;
            end
            ST_WPULSE: begin
                mem_ce_n     = 1'b0;
                mem_ce       = 1'b1;
                mem_we_n     = 1'b0;
                mem_dq_drive = 1'b1;
                strobe_en    = 1'b1;
            end
            ST_WHOLD: begin
                mem_dq_drive = 1'b1;
            end
            default: ;
        endcase
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign rsp_done   = done_q;
    assign rsp_rdata  = rdata_q;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    // R1: a ready controller leaves the RAM in standby with the bus released.
    p_standby_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n
                       && (&mem_byte_n) && !mem_dq_drive));

    // R3: output enable and write enable are never low together.
    p_we_oe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R7: the address moves only with write enable and low enable released on both sides.
    p_addr_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (mem_we_n && mem_ce_n && $past(mem_we_n) && $past(mem_ce_n)));

    // R8: the bus is never driven during or right after output enable.
    p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_drive |-> (mem_oe_n && $past(mem_oe_n)));

    // R6: write data does not change while it is being driven.
    p_wdata_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_drive && $past(mem_dq_drive)) |-> $stable(mem_dq_out));

    // R10: completion is a single-cycle pulse and busy means not ready.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

endmodule

// File: tb/tb_sram_async_ctrl.sv
// Bench for sram_async_ctrl: a byte-accurate RAM model on the pins, a shadow
// memory updated from the requirements, and a sweep of masks and addresses.
module tb_sram_async_ctrl;

    localparam int unsigned ADDR_W  = 19;
    localparam int unsigned LANES   = 2;
    localparam int unsigned LANE_W  = 8;
    localparam int unsigned DW      = LANES * LANE_W;
    localparam int unsigned T_ACC   = 3;
    localparam int unsigned T_WP    = 2;
    localparam int unsigned T_SETUP = 3;
    localparam int unsigned T_HOLD  = 2;
    localparam int unsigned T_TURN  = 3;
    localparam int unsigned PULSE   = (T_WP > T_SETUP) ? T_WP : T_SETUP;
    localparam int unsigned LAT_RD  = 2 + T_ACC;
    localparam int unsigned LAT_WR  = 2 + PULSE + T_HOLD;
    localparam int unsigned TURN_X  = (T_TURN > 2) ? T_TURN - 2 : 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic [LANES-1:0]  req_mask = '0;
    logic              rsp_done;
    logic [DW-1:0]     rsp_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_drive;
    logic [LANES-1:0]  mem_byte_n;
    logic [DW-1:0]     mem_dq_out;
    logic [DW-1:0]     mem_dq_in;

    sram_async_ctrl #(
        .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .T_ACC(T_ACC),
        .T_WP(T_WP), .T_SETUP(T_SETUP), .T_HOLD(T_HOLD), .T_TURN(T_TURN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_byte_n(mem_byte_n),
        .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_issued = 0;
    int n_done   = 0;
    bit mon_on   = 1'b0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Pin-level RAM model: 16 words indexed by address bits 3:0.
    logic [DW-1:0] ram [16];
    logic [DW-1:0] shadow [16];
    wire rd_en = !mem_ce_n && mem_ce && !mem_oe_n && mem_we_n;
    assign mem_dq_in = rd_en ?
        { mem_byte_n[1] ? 8'hEE : ram[mem_addr[3:0]][15:8],
          mem_byte_n[0] ? 8'hEE : ram[mem_addr[3:0]][7:0] } : 16'hDEAD;

    logic              p_we_n = 1'b1, p_oe_n = 1'b1, p_drive = 1'b0, p_ce_act = 1'b0;
    logic [LANES-1:0]  p_byte_n = '1;
    logic [DW-1:0]     p_dq = '0;
    logic [ADDR_W-1:0] p_addr = '0;
    int we_low = 0, oe_low = 0, hold_n = 0, oe_gap = 1000;
    bit seen_read = 1'b0;
    logic [ADDR_W-1:0] cur_addr = '0;

    // Cycle monitor sampled at the falling edge.
    always @(negedge clk) begin
        if (mon_on) begin
            if (rsp_done) n_done++;
            if (!mem_we_n) we_low++;
            if (!mem_oe_n) oe_low++;
            if (mem_dq_drive && mem_we_n) hold_n++;
            // R8: no drive next to output enable.
            if (mem_dq_drive && (!mem_oe_n || !p_oe_n))
                check(1'b0, "R8 contention", {31'b0, mem_oe_n}, 32'h1);
            // R7: address equals accepted command while enabled.
            if (!mem_ce_n)
                check(mem_addr == cur_addr, "R7 address held", mem_addr, cur_addr);
            // R4: strobes only while enabled.
            if (mem_ce_n && mem_byte_n != '1)
                check(1'b0, "R4 stray strobe", mem_byte_n, 2'b11);
            // Write edge: all releases together, commit to model.
            if (!p_we_n && mem_we_n) begin
                check(mem_ce_n && !mem_ce && mem_byte_n == '1, "R6 common release",
                      {mem_ce_n, mem_ce, mem_byte_n}, 4'b1011);
                check(we_low == PULSE, "R3 pulse width", we_low, PULSE);
                check(mem_dq_drive && mem_dq_out == p_dq, "R6 data at release", mem_dq_out, p_dq);
                for (int i = 0; i < LANES; i++)
                    if (!p_byte_n[i] && p_ce_act) ram[p_addr[3:0]][i*LANE_W +: LANE_W] = p_dq[i*LANE_W +: LANE_W];
                we_low = 0;
            end
            if (!mem_we_n)
                check(mem_oe_n && mem_dq_drive, "R3 write levels", {mem_oe_n, mem_dq_drive}, 2'b11);
            // Read window length.
            if (!p_oe_n && mem_oe_n) begin
                check(oe_low == T_ACC, "R2 access length", oe_low, T_ACC);
                oe_low = 0;
                seen_read = 1'b1;
            end
            if (!mem_oe_n)
                check(!mem_ce_n && mem_ce && mem_we_n, "R2 read levels",
                      {mem_ce_n, mem_ce, mem_we_n}, 3'b011);
            // Drive start after turnaround, drive end after hold.
            if (!p_drive && mem_dq_drive && seen_read)
                check(oe_gap >= T_TURN, "R8 turnaround gap", oe_gap, T_TURN);
            if (p_drive && !mem_dq_drive) begin
                check(hold_n == T_HOLD, "R6 hold length", hold_n, T_HOLD);
                hold_n = 0;
            end
            if (!mem_oe_n) oe_gap = 0; else oe_gap++;
        end
        p_we_n   = mem_we_n;
        p_oe_n   = mem_oe_n;
        p_drive  = mem_dq_drive;
        p_byte_n = mem_byte_n;
        p_dq     = mem_dq_out;
        p_addr   = mem_addr;
        p_ce_act = !mem_ce_n && mem_ce;
    end

    bit last_read = 1'b0;

    // One access through the handshake; checks busy state and latency.
    task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                          input logic [LANES-1:0] m, output logic [DW-1:0] rd);
        int k;
        int exp_lat;
        exp_lat = wr ? (LAT_WR + (last_read ? TURN_X : 0)) : LAT_RD;
        req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        cur_addr = a;
        n_issued++;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 1) check(!req_ready, "R10 busy after accept", req_ready, 0);
        end while (!rsp_done && k < 100);
        if (wr) check(k == exp_lat, "R9 write latency", k, exp_lat);
        else    check(k == exp_lat, "R5 read latency", k, exp_lat);
        rd = rsp_rdata;
        last_read = !wr;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        logic [DW-1:0] expv;
        logic [DW-1:0] lmask;
        logic [ADDR_W-1:0] a;
        for (int i = 0; i < 16; i++) begin ram[i] = '0; shadow[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(req_ready && mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && mem_byte_n == '1
              && !mem_dq_drive && !rsp_done, "R1 reset standby",
              {req_ready, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_drive}, 6'b110110);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        check(req_ready && mem_oe_n && !mem_dq_drive, "R1 idle after reset",
              {req_ready, mem_oe_n, mem_dq_drive}, 3'b110);

        // Sweep: every mask on every address, write then full and masked reads.
        for (int k = 0; k < 16; k++) begin
            for (int m = 0; m < 4; m++) begin
                a = {15'(k * 1237 + m * 77), 4'(k)};
                expv = 16'((k * 16'h1357) ^ (m * 16'h2468) ^ 16'hA55A);
                access(1'b1, a, expv, 2'(m), rd);
                lmask = {{8{m[1]}}, {8{m[0]}}};
                shadow[k] = (shadow[k] & ~lmask) | (expv & lmask);
                access(1'b0, a, '0, 2'b11, rd);
                check(rd == shadow[k], "R4 lane write", rd, shadow[k]);
                access(1'b0, a, '0, 2'(m), rd);
                check(rd == (shadow[k] & lmask), "R5 masked read zero lanes", rd, shadow[k] & lmask);
            end
            check(req_ready && mem_oe_n && !mem_dq_drive, "R1 standby between", req_ready, 1);
        end

        // Back-to-back full writes to different addresses, then read back.
        access(1'b1, 19'h7FFF3, 16'hBEEF, 2'b11, rd);
        access(1'b1, 19'h00004, 16'hC0DE, 2'b11, rd);
        shadow[3] = 16'hBEEF; shadow[4] = 16'hC0DE;
        access(1'b0, 19'h7FFF3, '0, 2'b11, rd);
        check(rd == 16'hBEEF, "R7 back-to-back write A", rd, 16'hBEEF);
        access(1'b0, 19'h00004, '0, 2'b11, rd);
        check(rd == 16'hC0DE, "R7 back-to-back write B", rd, 16'hC0DE);

        repeat (3) @(negedge clk);
        check(n_done == n_issued, "R10 one done per command", n_done, n_issued);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule